// File: doc/BRIEF.md
# Multiplexed pixel input unpacker

This block sits behind a graphics pixel port. Words arrive on a 16-bit data bus, one word per clock, with two words per pixel-clock period. A 4-bit format code chooses how these words are packed. Some layouts carry a whole RGB pixel in one word. Others spread a pixel over two or three words, or carry a YCrCb 4:2:2 stream. The block gathers the words of each pixel and rebuilds three 8-bit components from them. It then raises a one-cycle valid strobe together with the components. RGB fields of 5 or 6 bits are widened to 8 bits by replicating their top bits.

The format code may change at run time. A change, or the group-start marker, realigns the word counter so that the current word becomes the first word of a pixel group. For YCrCb, a strobe is issued for every luma sample. Each such strobe carries the latest blue-difference sample and the latest red-difference sample received.

Top module: `pix_unpacker`

## Requirements
- R1: While reset is asserted, and on leaving reset, `px_valid` is 0 and all three component outputs are 0x00. The first word processed after reset is word 0 of a pixel group.
- R2: Code 0 (one-word 5-6-5) takes R from `din[15:11]`, G from `din[10:5]` and B from `din[4:0]`. It gives one strobe per word.
- R3: Code 1 (one-word 5-5-5) takes R from `din[14:10]`, G from `din[9:5]` and B from `din[4:0]`. `din[15]` has no effect, and there is one strobe per word.
- R4: Codes 2 and 3 carry one pixel in two bytes on `din[7:0]`, with `din[15:8]` ignored. The first byte is {G low 3 bits, B[4:0]}. The second byte is {unused bit, R[4:0], G[4:3]} for code 2, or {R[4:0], G[5:3]} for code 3. The strobe follows the second byte only.
- R5: Code 4 carries 8-8-8 RGB as three bytes on `din[7:0]` in the order B, G, R. The strobe follows the third byte only.
- R6: Code 5 carries 8-8-8 RGB as two 12-bit half-words on `din[11:0]`, with `din[15:12]` ignored. The first half-word is {G[3:0], B[7:0]} and the second is {R[7:0], G[7:4]}.
- R7: A 5-bit field v widens to {v, v[4:2]} and a 6-bit field w widens to {w, w[5:4]}.
- R8: Code 6 carries bytes on `din[7:0]` in the repeating order Cb, Y, Cr, Y. A strobe follows each Y byte, with Cr, Y and Cb on outputs 0, 1 and 2, using the most recent Cb and Cr.
- R9: Code 7 carries Y on `din[15:8]` and chroma on `din[7:0]`. Chroma alternates Cb on even words and Cr on odd words. A strobe follows every word, using the most recent Cb and Cr (including the current word).
- R10: A change of `fmt_sel`, or `grp_start` high, makes the current word word 0 of a group, so no strobe fires until a full pixel has been gathered. A change of `fmt_sel` also clears the stored chroma to 0x00.
- R11: Codes 8 to 15 never raise `px_valid`.
- R12: Outputs are registered and appear in the cycle after the completing word. Between strobes the component outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, two words per pixel-clock period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 16 | Packed input word |
| grp_start | input | 1 | Marks the current word as word 0 of a pixel group |
| fmt_sel | input | 4 | Input layout code |
| px_valid | output | 1 | One-cycle strobe for a completed pixel or luma sample |
| px_c0 | output | 8 | R, or Cr for YCrCb |
| px_c1 | output | 8 | G, or Y for YCrCb |
| px_c2 | output | 8 | B, or Cb for YCrCb |

## Verification
The properties assume that `fmt_sel` and `grp_start` are clean, defined levels that are sampled once per clock. They also assume a code change applies to the word presented in the same cycle. The bench drives every input on the falling edge and holds it through the next rising edge, so a format switch always lands on a word boundary. The bench also waits out the internal reset-release stages before it relies on any strobe.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  localparam int PIX_DW = 16;
  localparam int PIX_CW = 8;
  localparam int FMT_W  = 4;
  localparam int BEAT_W = 2;

  localparam logic [FMT_W-1:0] FMT_RGB565_W  = 4'd0;
  localparam logic [FMT_W-1:0] FMT_RGB555_W  = 4'd1;
  localparam logic [FMT_W-1:0] FMT_RGB555_B2 = 4'd2;
  localparam logic [FMT_W-1:0] FMT_RGB565_B2 = 4'd3;
  localparam logic [FMT_W-1:0] FMT_RGB888_B3 = 4'd4;
  localparam logic [FMT_W-1:0] FMT_RGB888_H2 = 4'd5;
  localparam logic [FMT_W-1:0] FMT_YCC_B4    = 4'd6;
  localparam logic [FMT_W-1:0] FMT_YCC_W2    = 4'd7;

  // index of the final word in a group for each layout
  function automatic logic [BEAT_W-1:0] last_beat(input logic [FMT_W-1:0] f);
    logic [BEAT_W-1:0] r;
    case (f)
      FMT_RGB555_B2, FMT_RGB565_B2, FMT_RGB888_H2, FMT_YCC_W2: r = 2'd1;
      FMT_RGB888_B3:                                          r = 2'd2;
      FMT_YCC_B4:                                             r = 2'd3;
      default:                                                r = 2'd0;
    endcase
    return r;
  endfunction

  // widen an n-bit right-aligned field to PIX_CW bits by repeating its MSBs
  function automatic logic [PIX_CW-1:0] widen(input logic [PIX_CW-1:0] src,
                                              input int unsigned n);
    logic [PIX_CW-1:0] o;
    for (int i = 0; i < PIX_CW; i++) begin
      o[PIX_CW-1-i] = src[n-1-(i%n)];
    end
    return o;
  endfunction

endpackage

// File: rtl/pix_rst_sync.sv
module pix_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pix_beat_ctr.sv
module pix_beat_ctr
  import pix_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FMT_W-1:0]  fmt_sel,
  input  logic              grp_start,
  output logic [BEAT_W-1:0] beat,
  output logic              fmt_chg
);
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic [FMT_W-1:0]  fmt_q;
  logic              realign;

  always_comb begin
    fmt_chg = (fmt_sel != fmt_q);
    realign = fmt_chg | grp_start;
    beat    = realign ? '0 : cnt_q;
    if (beat == last_beat(fmt_sel)) cnt_d = '0;
    else                            cnt_d = beat + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fmt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      fmt_q <= fmt_sel;
    end
  end
endmodule

// File: rtl/pix_hold_regs.sv
module pix_hold_regs
  import pix_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_DW-1:0] din,
  input  logic [FMT_W-1:0]  fmt_sel,
  input  logic [BEAT_W-1:0] beat,
  input  logic              fmt_chg,
  output logic [11:0]       word0_q,
  output logic [PIX_CW-1:0] word1_q,
  output logic [PIX_CW-1:0] cb_q,
  output logic [PIX_CW-1:0] cr_prev
);
  logic              w0_en, w1_en, cb_en, cr_en;
  logic [PIX_CW-1:0] cr_q, cb_d, cr_d;
  logic [PIX_CW-1:0] chroma_in;

  always_comb begin
    chroma_in = din[PIX_CW-1:0];
    w0_en = (beat == 2'd0);
    w1_en = (beat == 2'd1);
    cb_en = ((fmt_sel == FMT_YCC_B4) || (fmt_sel == FMT_YCC_W2)) && (beat == 2'd0);
    cr_en = ((fmt_sel == FMT_YCC_B4) && (beat == 2'd2)) ||
            ((fmt_sel == FMT_YCC_W2) && (beat == 2'd1));
    cr_prev = fmt_chg ? '0 : cr_q;
    cb_d = fmt_chg ? '0 : cb_q;
    if (cb_en) cb_d = chroma_in;
    cr_d = cr_prev;
    if (cr_en) cr_d = chroma_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word0_q <= '0;
      word1_q <= '0;
      cb_q    <= '0;
      cr_q    <= '0;
    end else begin
      if (w0_en) word0_q <= din[11:0];
      if (w1_en) word1_q <= din[PIX_CW-1:0];
      cb_q <= cb_d;
      cr_q <= cr_d;
    end
  end
endmodule

// File: rtl/pix_assemble.sv
module pix_assemble
  import pix_unpack_pkg::*;
(
  input  logic [PIX_DW-1:0] din,
  input  logic [FMT_W-1:0]  fmt_sel,
  input  logic [BEAT_W-1:0] beat,
  input  logic [11:0]       word0_q,
  input  logic [PIX_CW-1:0] word1_q,
  input  logic [PIX_CW-1:0] cb_q,
  input  logic [PIX_CW-1:0] cr_prev,
  output logic              strobe,
  output logic [PIX_CW-1:0] c0,
  output logic [PIX_CW-1:0] c1,
  output logic [PIX_CW-1:0] c2
);
  always_comb begin
    strobe = 1'b0;
    c0 = '0;
    c1 = '0;
    c2 = '0;
    case (fmt_sel)
      FMT_RGB565_W: begin
        strobe = 1'b1;
        c0 = widen({3'b0, din[15:11]}, 5);
        c1 = widen({2'b0, din[10:5]}, 6);
        c2 = widen({3'b0, din[4:0]}, 5);
      end
      FMT_RGB555_W: begin
        strobe = 1'b1;
        c0 = widen({3'b0, din[14:10]}, 5);
        c1 = widen({3'b0, din[9:5]}, 5);
        c2 = widen({3'b0, din[4:0]}, 5);
      end
      FMT_RGB555_B2: begin
        strobe = (beat == 2'd1);
        c0 = widen({3'b0, din[6:2]}, 5);
        c1 = widen({3'b0, din[1:0], word0_q[7:5]}, 5);
        c2 = widen({3'b0, word0_q[4:0]}, 5);
      end
      FMT_RGB565_B2: begin
        strobe = (beat == 2'd1);
        c0 = widen({3'b0, din[7:3]}, 5);
        c1 = widen({2'b0, din[2:0], word0_q[7:5]}, 6);
        c2 = widen({3'b0, word0_q[4:0]}, 5);
      end
      FMT_RGB888_B3: begin
        strobe = (beat == 2'd2);
        c0 = din[7:0];
        c1 = word1_q;
        c2 = word0_q[7:0];
      end
      FMT_RGB888_H2: begin
        strobe = (beat == 2'd1);
        c0 = din[11:4];
        c1 = {din[3:0], word0_q[11:8]};
        c2 = word0_q[7:0];
      end
      FMT_YCC_B4: begin
        strobe = beat[0];
        c0 = cr_prev;
        c1 = din[7:0];
        c2 = cb_q;
      end
      FMT_YCC_W2: begin
        strobe = 1'b1;
        c1 = din[15:8];
        if (beat == 2'd0) begin
          c0 = cr_prev;
          c2 = din[7:0];
        end else begin
          c0 = din[7:0];
          c2 = cb_q;
        end
      end
      default: begin
        strobe = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
  import pix_unpack_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_DW-1:0] din,
  input  logic              grp_start,
  input  logic [FMT_W-1:0]  fmt_sel,
  output logic              px_valid,
  output logic [PIX_CW-1:0] px_c0,
  output logic [PIX_CW-1:0] px_c1,
  output logic [PIX_CW-1:0] px_c2
);
  logic              rst_i;
  logic [BEAT_W-1:0] beat;
  logic              fmt_chg;
  logic [11:0]       word0_q;
  logic [PIX_CW-1:0] word1_q, cb_q, cr_prev;
  logic              strobe;
  logic [PIX_CW-1:0] a0, a1, a2;
  logic              valid_q;
  logic [PIX_CW-1:0] c0_q, c1_q, c2_q, c0_d, c1_d, c2_d;

  pix_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i)
  );

  pix_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_i), .fmt_sel(fmt_sel), .grp_start(grp_start),
    .beat(beat), .fmt_chg(fmt_chg)
  );

  pix_hold_regs u_hold (
    .clk(clk), .rst_n(rst_i), .din(din), .fmt_sel(fmt_sel), .beat(beat),
    .fmt_chg(fmt_chg), .word0_q(word0_q), .word1_q(word1_q),
    .cb_q(cb_q), .cr_prev(cr_prev)
  );

  pix_assemble u_asm (
    .din(din), .fmt_sel(fmt_sel), .beat(beat), .word0_q(word0_q),
    .word1_q(word1_q), .cb_q(cb_q), .cr_prev(cr_prev),
    .strobe(strobe), .c0(a0), .c1(a1), .c2(a2)
  );

  always_comb begin
    c0_d = strobe ? a0 : c0_q;
    c1_d = strobe ? a1 : c1_q;
    c2_d = strobe ? a2 : c2_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      valid_q <= 1'b0;
      c0_q    <= '0;
      c1_q    <= '0;
      c2_q    <= '0;
    end else begin
      valid_q <= strobe;
      c0_q    <= c0_d;
      c1_q    <= c1_d;
      c2_q    <= c2_d;
    end
  end

  assign px_valid = valid_q;
  assign px_c0    = c0_q;
  assign px_c1    = c1_q;
  assign px_c2    = c2_q;
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
  import pix_unpack_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [FMT_W-1:0]  fmt_sel,
  input logic              px_valid,
  input logic [PIX_CW-1:0] px_c0,
  input logic [PIX_CW-1:0] px_c1,
  input logic [PIX_CW-1:0] px_c2
);
  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R11
  undef_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> ($past(fmt_sel) < 4'd8));

  // R10
  realign_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q == 2'd3) && ($past(fmt_sel) != $past(fmt_sel, 2)) &&
     ($past(fmt_sel) >= 4'd2) && ($past(fmt_sel) <= 4'd6)) |-> !px_valid);

  // R12
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid |-> ($stable(px_c0) && $stable(px_c1) && $stable(px_c2)));

  // R2
  single_word_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q == 2'd3) && ($past(fmt_sel) <= 4'd1)) |-> px_valid);

  // R9
  wide_ycc_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q == 2'd3) && ($past(fmt_sel) == 4'd7)) |-> px_valid);

  // R8
  byte_ycc_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q == 2'd3) && px_valid && (fmt_sel == 4'd6)) |=> !px_valid);
endmodule

bind pix_unpacker pix_unpack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .px_valid(px_valid),
  .px_c0(px_c0), .px_c1(px_c1), .px_c2(px_c2)
);

// File: tb/sim_pix_unpacker.sv
module sim_pix_unpacker;
  logic        clk;
  logic        rst_n;
  logic [15:0] din;
  logic        grp_start;
  logic [3:0]  fmt_sel;
  logic        px_valid;
  logic [7:0]  px_c0, px_c1, px_c2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pix_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .grp_start(grp_start),
    .fmt_sel(fmt_sel), .px_valid(px_valid),
    .px_c0(px_c0), .px_c1(px_c1), .px_c2(px_c2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {fmt, grp_start, din, exp_valid, exp_c0, exp_c1, exp_c2}
  localparam int NV = 37;
  localparam logic [45:0] VEC [NV] = '{
    {4'd0, 1'b0, 16'hF81F, 1'b1, 8'hFF, 8'h00, 8'hFF},  // R2 R7
    {4'd0, 1'b0, 16'h07E0, 1'b1, 8'h00, 8'hFF, 8'h00},
    {4'd0, 1'b0, 16'h8410, 1'b1, 8'h84, 8'h82, 8'h84},  // R7 replication
    {4'd1, 1'b0, 16'hFC00, 1'b1, 8'hFF, 8'h00, 8'h00},  // R3
    {4'd1, 1'b0, 16'h8000, 1'b1, 8'h00, 8'h00, 8'h00},  // R3 top bit ignored
    {4'd1, 1'b0, 16'h7FFF, 1'b1, 8'hFF, 8'hFF, 8'hFF},
    {4'd3, 1'b0, 16'hABE5, 1'b0, 8'hFF, 8'hFF, 8'hFF},  // R4 R12 hold
    {4'd3, 1'b0, 16'h005A, 1'b1, 8'h5A, 8'h5D, 8'h29},
    {4'd2, 1'b0, 16'h003F, 1'b0, 8'h5A, 8'h5D, 8'h29},  // R10 realign
    {4'd2, 1'b0, 16'hFFFF, 1'b1, 8'hFF, 8'hCE, 8'hFF},  // R4 unused bit
    {4'd4, 1'b0, 16'h0011, 1'b0, 8'hFF, 8'hCE, 8'hFF},  // R5
    {4'd4, 1'b0, 16'h0022, 1'b0, 8'hFF, 8'hCE, 8'hFF},
    {4'd4, 1'b0, 16'h0033, 1'b1, 8'h33, 8'h22, 8'h11},
    {4'd5, 1'b0, 16'hF3BC, 1'b0, 8'h33, 8'h22, 8'h11},  // R6
    {4'd5, 1'b0, 16'hFD5E, 1'b1, 8'hD5, 8'hE3, 8'hBC},
    {4'd6, 1'b0, 16'h0010, 1'b0, 8'hD5, 8'hE3, 8'hBC},  // R8
    {4'd6, 1'b0, 16'h0020, 1'b1, 8'h00, 8'h20, 8'h10},  // R10 chroma cleared
    {4'd6, 1'b0, 16'h0030, 1'b0, 8'h00, 8'h20, 8'h10},
    {4'd6, 1'b0, 16'h0040, 1'b1, 8'h30, 8'h40, 8'h10},
    {4'd6, 1'b0, 16'h0050, 1'b0, 8'h30, 8'h40, 8'h10},
    {4'd6, 1'b0, 16'h0060, 1'b1, 8'h30, 8'h60, 8'h50},
    {4'd7, 1'b0, 16'h7080, 1'b1, 8'h00, 8'h70, 8'h80},  // R9
    {4'd7, 1'b0, 16'h9011, 1'b1, 8'h11, 8'h90, 8'h80},
    {4'd7, 1'b0, 16'hA022, 1'b1, 8'h11, 8'hA0, 8'h22},
    {4'd4, 1'b0, 16'h0001, 1'b0, 8'h11, 8'hA0, 8'h22},  // R10 group start
    {4'd4, 1'b0, 16'h0002, 1'b0, 8'h11, 8'hA0, 8'h22},
    {4'd4, 1'b1, 16'h00AA, 1'b0, 8'h11, 8'hA0, 8'h22},
    {4'd4, 1'b0, 16'h00BB, 1'b0, 8'h11, 8'hA0, 8'h22},
    {4'd4, 1'b0, 16'h00CC, 1'b1, 8'hCC, 8'hBB, 8'hAA},
    {4'd3, 1'b0, 16'h0012, 1'b0, 8'hCC, 8'hBB, 8'hAA},  // R10 switch mid group
    {4'd0, 1'b0, 16'h001F, 1'b1, 8'h00, 8'h00, 8'hFF},
    {4'd15, 1'b0, 16'h1234, 1'b0, 8'h00, 8'h00, 8'hFF}, // R11
    {4'd15, 1'b0, 16'h5678, 1'b0, 8'h00, 8'h00, 8'hFF},
    {4'd6, 1'b0, 16'h0010, 1'b0, 8'h00, 8'h00, 8'hFF},
    {4'd6, 1'b0, 16'h0020, 1'b1, 8'h00, 8'h20, 8'h10},
    {4'd6, 1'b1, 16'h0070, 1'b0, 8'h00, 8'h20, 8'h10},  // R10 in byte YCrCb
    {4'd6, 1'b0, 16'h0080, 1'b1, 8'h00, 8'h80, 8'h70}
  };

  function automatic string tag_of(input logic [3:0] f);
    case (f)
      4'd0:       return "R2,R7,R12";
      4'd1:       return "R3,R7";
      4'd2, 4'd3: return "R4,R7,R10";
      4'd4:       return "R5,R10";
      4'd5:       return "R6";
      4'd6:       return "R8,R10";
      4'd7:       return "R9";
      default:    return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic v,
                     input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2);
    checks++;
    if (px_valid !== v || px_c0 !== e0 || px_c1 !== e1 || px_c2 !== e2) begin
      errors++;
      $display("FAIL %s actual v=%0b %02h %02h %02h expected v=%0b %02h %02h %02h",
               tag, px_valid, px_c0, px_c1, px_c2, v, e0, e1, e2);
    end
  endtask

  task automatic drive(input logic [3:0] f, input logic s, input logic [15:0] d);
    @(negedge clk);
    fmt_sel   = f;
    grp_start = s;
    din       = d;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    din = '0;
    grp_start = 1'b0;
    fmt_sel = 4'd0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 in reset", 1'b0, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 after release", 1'b0, 8'h00, 8'h00, 8'h00);
    @(posedge clk);
    #2;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][45:42], VEC[i][41], VEC[i][40:25]);
      chk(tag_of(VEC[i][45:42]), VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R1: reset in the middle of a three-byte group
    drive(4'd4, 1'b0, 16'h0001);
    drive(4'd4, 1'b0, 16'h0002);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 mid-run reset", 1'b0, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(4'd4, 1'b1, 16'h0044);
    chk("R5 after reset", 1'b0, px_c0, px_c1, px_c2);
    drive(4'd4, 1'b0, 16'h0055);
    chk("R5 after reset", 1'b0, px_c0, px_c1, px_c2);
    drive(4'd4, 1'b0, 16'h0066);
    chk("R5 after reset", 1'b1, 8'h66, 8'h55, 8'h44);

    // R12: hold over idle undefined-code words
    drive(4'd9, 1'b0, 16'hFFFF);
    chk("R11,R12 hold", 1'b0, 8'h66, 8'h55, 8'h44);
    drive(4'd9, 1'b1, 16'h0000);
    chk("R11,R12 hold", 1'b0, 8'h66, 8'h55, 8'h44);

    // R6: upper nibble ignored in half-word mode
    drive(4'd5, 1'b0, 16'h0BC3);
    drive(4'd5, 1'b0, 16'h0A5F);
    chk("R6 upper nibble", 1'b1, 8'hA5, 8'hFB, 8'hC3);
    drive(4'd5, 1'b0, 16'hFBC3);
    drive(4'd5, 1'b0, 16'hFA5F);
    chk("R6 upper nibble", 1'b1, 8'hA5, 8'hFB, 8'hC3);

    finish_run();
  end
endmodule